// File: doc/BRIEF.md
# Tri-State Phase-Frequency Comparator with Lock Flag

This block compares a reference input with a feedback input that comes from the oscillator divider of a digital phase-locked loop model. Both inputs are asynchronous to the system clock. Each one passes through a synchronizer and then a rising-edge detector. A memory network of two request flip-flops, one for "speed up" and one for "slow down", turns the order of the edges into a correction that can take three states.

The correction is modelled as an output-enable plus a level. When the enable is set, the output drives high (raise the oscillator frequency) or drives low (lower it). When the enable is clear, the output floats. A phase-pulse flag is high whenever the correction floats. Once the loop settles with zero phase difference between the two rising edges, the output floats nearly all the time, so the flag serves as a lock indicator.

Only rising edges count, so the duty cycle of either input has no effect. When the reference is missing, the feedback edges hold the output low, which drives the oscillator toward its lowest frequency.

Top module: `pfd_tristate`

## Requirements
- R1: Only rising edges of refIn and fbIn act on the comparator. A high level held for any number of cycles, and a falling edge, do not change the correction.
- R2: A reference rising edge that arrives while the output floats sets the drive-high state (outEn=1, outLevel=1). That state persists until a feedback rising edge arrives, and then the output floats again.
- R3: A feedback rising edge that arrives while the output floats sets the drive-low state (outEn=1, outLevel=0). That state persists until a reference rising edge arrives, and then the output floats again.
- R4: If both requests would be set in the same clock, both clear. upReq and dnReq are never high together. Rising edges on both inputs in the same cycle leave the output floating.
- R5: phasePulse is 1 exactly when outEn is 0.
- R6: An extra reference rising edge during drive-high is treated as a real edge. The output stays in drive-high until the next feedback rising edge.
- R7: With no reference edges, repeated feedback rising edges keep the output in drive-low.
- R8: The encoding is as follows. outEn=1 with outLevel=1 is drive high. outEn=1 with outLevel=0 is drive low. outEn=0 is float. The ports upReq and dnReq equal the drive-high and drive-low states.
- R9: A synchronous active-high rst clears both requests. While reset is held and after it is released, the output floats and phasePulse is 1.
- R10: A rising input level that is present before clock edge k changes the correction at edge k+SYNC_STAGES, which is the third edge with the default depth of 2. The output does not change at any earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| refIn | input | 1 | Reference signal, asynchronous |
| fbIn | input | 1 | Feedback signal from the divider, asynchronous |
| upReq | output | 1 | Drive-high request |
| dnReq | output | 1 | Drive-low request |
| outEn | output | 1 | Correction output enable (0 = float) |
| outLevel | output | 1 | Driven level when outEn is 1 |
| phasePulse | output | 1 | High while the correction floats (lock flag) |

## Verification
The inputs are driven with reference-first and feedback-first edge orders. Comparing these two shows that the drive direction follows which edge comes first. Edges on both inputs in the same cycle separate a correct clearing of the requests from a design that lets one request win. Runs of feedback-only edges, and repeated reference edges, check that a missing or spurious edge holds the current drive state instead of toggling it. Pulse widths from one to eight cycles, and a check of the latency edge by edge, show that only the rising edge matters and when it takes effect.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // One-cycle rising-edge events, from the datapath to the control
  typedef struct packed {
    logic refRise;
    logic fbRise;
  } edge_strobes_t;

  // Request state, from the control back to the top
  typedef struct packed {
    logic up;
    logic dn;
  } pfd_req_t;
endpackage

// File: rtl/pfd_edge_path.sv
module pfd_edge_path #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   refIn,
  input  logic                   fbIn,
  output pfd_pkg::edge_strobes_t strobes
);
  localparam int NUM_CH = 2;

  logic [NUM_CH-1:0] rawIn;
  logic [NUM_CH-1:0] riseEv;

  assign rawIn = {fbIn, refIn};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [SYNC_STAGES-1:0] syncChain;
    logic                   lastLvl;

    always_ff @(posedge clk) begin
      if (rst) begin
        syncChain <= '0;
        lastLvl   <= 1'b0;
      end else begin
        syncChain <= {syncChain[SYNC_STAGES-2:0], rawIn[ch]};
        lastLvl   <= syncChain[SYNC_STAGES-1];
      end
    end

    assign riseEv[ch] = syncChain[SYNC_STAGES-1] & ~lastLvl;
  end

  assign strobes.refRise = riseEv[0];
  assign strobes.fbRise  = riseEv[1];
endmodule

// File: rtl/pfd_req_ctrl.sv
module pfd_req_ctrl (
  input  logic                   clk,
  input  logic                   rst,
  input  pfd_pkg::edge_strobes_t strobes,
  output pfd_pkg::pfd_req_t      req
);
  logic upNext, dnNext;

  always_comb begin
    upNext = req.up | strobes.refRise;
    dnNext = req.dn | strobes.fbRise;
    if (upNext && dnNext) begin
      upNext = 1'b0;
      dnNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req.up <= 1'b0;
      req.dn <= 1'b0;
    end else begin
      req.up <= upNext;
      req.dn <= dnNext;
    end
  end
endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic refIn,
  input  logic fbIn,
  output logic upReq,
  output logic dnReq,
  output logic outEn,
  output logic outLevel,
  output logic phasePulse
);
  pfd_pkg::edge_strobes_t strobes;
  pfd_pkg::pfd_req_t      req;

  pfd_edge_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk     (clk),
    .rst     (rst),
    .refIn   (refIn),
    .fbIn    (fbIn),
    .strobes (strobes)
  );

  pfd_req_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .req     (req)
  );

  assign upReq      = req.up;
  assign dnReq      = req.dn;
  assign outEn      = req.up | req.dn;
  assign outLevel   = req.up;
  assign phasePulse = ~(req.up | req.dn);
endmodule

// File: rtl/pfd_tristate_chk.sv
module pfd_tristate_chk (
  input logic clk,
  input logic rst,
  input logic refRise,
  input logic fbRise,
  input logic upReq,
  input logic dnReq,
  input logic outEn,
  input logic outLevel,
  input logic phasePulse
);
  // R4
  req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(upReq && dnReq));

  // R4
  both_edges_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (refRise && fbRise) |=> (!upReq && !dnReq));

  // R2
  up_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (upReq && !fbRise) |=> upReq);

  // R2
  up_release_chk: assert property (@(posedge clk) disable iff (rst)
    (upReq && fbRise) |=> !outEn);

  // R3
  dn_release_chk: assert property (@(posedge clk) disable iff (rst)
    (dnReq && refRise) |=> !outEn);

  // R7
  dn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dnReq && !refRise) |=> dnReq);

  // R5
  flag_float_chk: assert property (@(posedge clk) disable iff (rst)
    phasePulse |-> (!upReq && !dnReq));

  // R8
  level_enc_chk: assert property (@(posedge clk) disable iff (rst)
    outEn |-> (outLevel == upReq));

  // R9
  reset_float_chk: assert property (@(posedge clk)
    $past(rst) |-> (!outEn && phasePulse));
endmodule

bind pfd_tristate pfd_tristate_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .refRise    (strobes.refRise),
  .fbRise     (strobes.fbRise),
  .upReq      (upReq),
  .dnReq      (dnReq),
  .outEn      (outEn),
  .outLevel   (outLevel),
  .phasePulse (phasePulse)
);

// File: tb/sim_pfd_tristate.sv
module sim_pfd_tristate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refIn = 1'b0;
  logic fbIn = 1'b0;
  logic upReq, dnReq, outEn, outLevel, phasePulse;
  int   errors = 0;
  int   checks = 0;
  int   cycles = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  pfd_tristate u0 (
    .clk(clk), .rst(rst), .refIn(refIn), .fbIn(fbIn),
    .upReq(upReq), .dnReq(dnReq), .outEn(outEn),
    .outLevel(outLevel), .phasePulse(phasePulse)
  );

  // Vector: [7:6] action (0 idle, 1 ref, 2 fb, 3 both), [5:2] high width,
  // [1] expected outEn, [0] expected outLevel
  localparam int NV = 12;
  localparam logic [7:0] VEC [NV] = '{
    {2'd1, 4'd1, 1'b1, 1'b1},  // R2 ref leads
    {2'd1, 4'd6, 1'b1, 1'b1},  // R6 spurious ref edge
    {2'd2, 4'd2, 1'b0, 1'b0},  // R2 fb ends drive high
    {2'd2, 4'd8, 1'b1, 1'b0},  // R3 fb leads
    {2'd1, 4'd3, 1'b0, 1'b0},  // R3 ref ends drive low
    {2'd3, 4'd2, 1'b0, 1'b0},  // R4 coincident edges
    {2'd2, 4'd1, 1'b1, 1'b0},  // R7 ref absent
    {2'd2, 4'd5, 1'b1, 1'b0},  // R7
    {2'd2, 4'd2, 1'b1, 1'b0},  // R7
    {2'd0, 4'd4, 1'b1, 1'b0},  // R1 idle keeps state
    {2'd1, 4'd7, 1'b0, 1'b0},  // R3
    {2'd3, 4'd8, 1'b0, 1'b0}   // R4
  };

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkState(input string tag, input logic en, input logic lvl);
    chk(tag, {3'b0, outEn}, {3'b0, en});
    if (en) chk({tag, " R8 level"}, {upReq, dnReq, 1'b0, outLevel}, {lvl, ~lvl, 1'b0, lvl});
    else    chk({tag, " R8 float"}, {upReq, dnReq, 2'b0}, 4'b0);
    chk({tag, " R5 flag"}, {3'b0, phasePulse}, {3'b0, ~en});
  endtask

  task automatic stim(input logic [1:0] act, input int width);
    @(negedge clk);
    refIn = act[0];
    fbIn  = act[1];
    repeat (width) @(negedge clk);
    refIn = 1'b0;
    fbIn  = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chkState("R9 during reset", 1'b0, 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chkState("R9 after reset", 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      stim(VEC[i][7:6], int'(VEC[i][5:2]));
      chkState($sformatf("vector %0d", i), VEC[i][1], VEC[i][0]);
    end

    // R10 latency: output changes exactly at the third edge
    @(negedge clk);
    refIn = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 no change after two edges", {3'b0, outEn}, 4'd0);
    @(negedge clk);
    chk("R10 drive high after third edge", {2'b0, outEn, outLevel}, 4'b0011);
    // R1 held level does not act again, falling edge has no effect
    repeat (10) @(negedge clk);
    chkState("R1 held high", 1'b1, 1'b1);
    refIn = 1'b0;
    repeat (5) @(negedge clk);
    chkState("R1 falling edge", 1'b1, 1'b1);

    // R9 reset clears an active correction
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chkState("R9 reset clears drive high", 1'b0, 1'b0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chkState("R9 float after release", 1'b0, 1'b0);

    // R3 then R4: feedback lead cleared by coincident edges
    stim(2'b10, 3);
    chkState("R3 fb lead again", 1'b1, 1'b0);
    stim(2'b11, 2);
    chkState("R4 coincident while low", 1'b0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule